// File: doc/BRIEF.md
# Peak Candidate Selector

This block sits after a tower-sum stage in a calorimeter trigger path. For each event it takes a flag for every cell of an 8 by 8 eta/phi grid, plus the window energy of that cell. A set flag means the cell's window has already passed the energy threshold. The block reduces these cells to a short ranked list of peak candidates for a downstream pair-mass stage.

Each candidate carries a valid bit, a 6-bit position address and a 10-bit energy. The list holds at most four entries. When more cells are flagged, the four most energetic are kept, and unused slots read as zero.

Events arrive on a valid/ready stream and results leave on a second valid/ready stream. An event is taken only when the block is idle and no earlier result is still waiting. The block then scans the captured cells, one cell per cycle, in ascending address order. The result appears a fixed number of cycles later and stays frozen until the consumer takes it. Back-pressure on the output therefore stalls the input: while a result waits, `in_ready` stays low.

Top module: `pcs_peak_select`

## Requirements
- R1: `in_ready` is high exactly when no scan is running and no result is pending. An event is taken on a clock edge where `in_valid` and `in_ready` are both high.
- R2: `out_valid` rises exactly NCELL (64) clock edges after the accepting edge, and each accepted event yields exactly one result.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` and all candidate outputs hold steady. A result is consumed on an edge with `out_valid` and `out_ready` both high, and `in_ready` is high after that edge.
- R4: Only cells whose `in_hit` bit is set can become candidates. An unflagged cell never appears, whatever its energy.
- R5: At most four candidates are reported. When more than four cells are flagged, the four with the largest reported energy are kept.
- R6: Valid candidates fill slots from slot 0 upward in descending energy order. Between equal energies, the lower address takes the lower slot.
- R7: Cell i has eta = i/8 and phi = i%8, and its address is {eta[2:0], phi[2:0]}, which equals i. Its energy is `in_energy[i*12 +: 12]`. Slot k uses `cand_addr[k*6 +: 6]` and `cand_energy[k*10 +: 10]`.
- R8: An input energy of 1024 or more is reported as 1023. Smaller energies are reported unchanged, and ranking uses the reported value.
- R9: A slot with its `cand_valid` bit clear reports address 0 and energy 0.
- R10: After reset, `in_ready` is 1, `out_valid` is 0, and all candidate outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An event is offered |
| in_ready | output | 1 | The block can take an event |
| in_hit | input | 64 | Per-cell flag: the cell passed threshold |
| in_energy | input | 768 | Per-cell window energy, 12 bits per cell |
| out_valid | output | 1 | A candidate list is available |
| out_ready | input | 1 | The consumer takes the list |
| cand_valid | output | 4 | Per-slot valid bit, slot 0 first |
| cand_addr | output | 24 | Per-slot address {eta, phi}, 6 bits each |
| cand_energy | output | 40 | Per-slot reported energy, 10 bits each |

## Verification
The selection is exercised with several kinds of flag map:
- An empty map shows that every slot clears.
- A single flag shows correct placement and address packing.
- Sparse maps with fewer than four flags show that trailing slots stay zero.
- Dense and full maps show that the top four are picked over many contenders.

Energy ranges are chosen to separate different faults:
- Narrow ranges force many ties and separate the lower-address tie rule from a later-wins rule.
- Values above 1023 show saturation, and expose any ranking on raw instead of reported energy.
- Large energies on unflagged cells expose leakage of unflagged cells.

Random hold times on `out_ready` test output stability and the coupling between input and output readiness. Each event also checks latency to the exact edge.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned DEF_ETA_W  = 3;
  localparam int unsigned DEF_PHI_W  = 3;
  localparam int unsigned DEF_IN_EW  = 12;
  localparam int unsigned DEF_OUT_EW = 10;
  localparam int unsigned DEF_NCAND  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } pcs_state_e;
endpackage

// File: rtl/pcs_sat.sv
module pcs_sat #(
  parameter int unsigned IN_W  = 12,
  parameter int unsigned OUT_W = 10
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  generate
    if (IN_W <= OUT_W) begin : g_pad
      assign dout = OUT_W'(din);
    end else begin : g_clip
      logic over;
      assign over = |din[IN_W-1:OUT_W];
      assign dout = over ? {OUT_W{1'b1}} : din[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pcs_topk_insert.sv
module pcs_topk_insert #(
  parameter int unsigned NCAND  = 4,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned EW     = 10
) (
  input  logic [NCAND-1:0]        cur_v,
  input  logic [NCAND*ADDR_W-1:0] cur_a,
  input  logic [NCAND*EW-1:0]     cur_e,
  input  logic                    new_en,
  input  logic [ADDR_W-1:0]       new_a,
  input  logic [EW-1:0]           new_e,
  output logic [NCAND-1:0]        nxt_v,
  output logic [NCAND*ADDR_W-1:0] nxt_a,
  output logic [NCAND*EW-1:0]     nxt_e
);
  logic [NCAND-1:0] beats;

  genvar k;
  generate
    for (k = 0; k < NCAND; k++) begin : g_slot
      // strict greater keeps the earlier (lower) address ahead on ties
      assign beats[k] = new_en && (!cur_v[k] || (new_e > cur_e[k*EW +: EW]));
      if (k == 0) begin : g_head
        always_comb begin
          if (beats[0]) begin
            nxt_v[0]          = 1'b1;
            nxt_a[0 +: ADDR_W] = new_a;
            nxt_e[0 +: EW]     = new_e;
          end else begin
            nxt_v[0]          = cur_v[0];
            nxt_a[0 +: ADDR_W] = cur_a[0 +: ADDR_W];
            nxt_e[0 +: EW]     = cur_e[0 +: EW];
          end
        end
      end else begin : g_tail
        always_comb begin
          if (beats[k] && !beats[k-1]) begin
            nxt_v[k]               = 1'b1;
            nxt_a[k*ADDR_W +: ADDR_W] = new_a;
            nxt_e[k*EW +: EW]         = new_e;
          end else if (beats[k]) begin
            nxt_v[k]               = cur_v[k-1];
            nxt_a[k*ADDR_W +: ADDR_W] = cur_a[(k-1)*ADDR_W +: ADDR_W];
            nxt_e[k*EW +: EW]         = cur_e[(k-1)*EW +: EW];
          end else begin
            nxt_v[k]               = cur_v[k];
            nxt_a[k*ADDR_W +: ADDR_W] = cur_a[k*ADDR_W +: ADDR_W];
            nxt_e[k*EW +: EW]         = cur_e[k*EW +: EW];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pcs_scan_ctrl.sv
module pcs_scan_ctrl
  import pcs_pkg::*;
#(
  parameter int unsigned NCELL = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     start,
  output logic                     step,
  output logic [$clog2(NCELL)-1:0] idx
);
  localparam int unsigned IDX_W = $clog2(NCELL);
  localparam int unsigned LAT_W = $clog2(NCELL + 1) + 1;

  pcs_state_e state;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign start     = in_valid && in_ready;
  assign step      = (state == ST_SCAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_SCAN;
          idx   <= '0;
        end
        ST_SCAN: begin
          idx <= idx + 1'b1;
          if (idx == IDX_W'(NCELL - 1)) state <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // independent cycle counter from the accepting edge, used only by the checks
  logic [LAT_W-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= '0;
    else if (start) lat_cnt <= '0;
    else if (lat_cnt != {LAT_W{1'b1}}) lat_cnt <= lat_cnt + 1'b1;
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid && !step);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_cnt == LAT_W'(NCELL));

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);
endmodule

// File: rtl/pcs_peak_select.sv
module pcs_peak_select
  import pcs_pkg::*;
#(
  parameter int unsigned ETA_W  = DEF_ETA_W,
  parameter int unsigned PHI_W  = DEF_PHI_W,
  parameter int unsigned IN_EW  = DEF_IN_EW,
  parameter int unsigned OUT_EW = DEF_OUT_EW,
  parameter int unsigned NCAND  = DEF_NCAND,
  localparam int unsigned ADDR_W = ETA_W + PHI_W,
  localparam int unsigned NCELL  = 1 << ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NCELL-1:0]         in_hit,
  input  logic [NCELL*IN_EW-1:0]   in_energy,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NCAND-1:0]         cand_valid,
  output logic [NCAND*ADDR_W-1:0]  cand_addr,
  output logic [NCAND*OUT_EW-1:0]  cand_energy
);
  logic              start, step;
  logic [ADDR_W-1:0] idx;

  pcs_scan_ctrl #(.NCELL(NCELL)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .start(start), .step(step), .idx(idx)
  );

  logic [NCELL-1:0]       hit_q;
  logic [NCELL*IN_EW-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= '0;
      en_q  <= '0;
    end else if (start) begin
      hit_q <= in_hit;
      en_q  <= in_energy;
    end
  end

  logic [IN_EW-1:0]  cell_raw;
  logic [OUT_EW-1:0] cell_sat;
  assign cell_raw = en_q[idx*IN_EW +: IN_EW];

  pcs_sat #(.IN_W(IN_EW), .OUT_W(OUT_EW)) u_sat (.din(cell_raw), .dout(cell_sat));

  logic [NCAND-1:0]        lst_v, nxt_v;
  logic [NCAND*ADDR_W-1:0] lst_a, nxt_a;
  logic [NCAND*OUT_EW-1:0] lst_e, nxt_e;

  pcs_topk_insert #(.NCAND(NCAND), .ADDR_W(ADDR_W), .EW(OUT_EW)) u_ins (
    .cur_v(lst_v), .cur_a(lst_a), .cur_e(lst_e),
    .new_en(hit_q[idx]), .new_a(idx), .new_e(cell_sat),
    .nxt_v(nxt_v), .nxt_a(nxt_a), .nxt_e(nxt_e)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      lst_v <= '0;
      lst_a <= '0;
      lst_e <= '0;
    end else if (step) begin
      lst_v <= nxt_v;
      lst_a <= nxt_a;
      lst_e <= nxt_e;
    end
  end

  assign cand_valid  = lst_v;
  assign cand_addr   = lst_a;
  assign cand_energy = lst_e;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(cand_valid)
      && $stable(cand_addr) && $stable(cand_energy));

  genvar k;
  generate
    for (k = 0; k < NCAND; k++) begin : g_chk
      p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cand_valid[k]) |->
          cand_addr[k*ADDR_W +: ADDR_W] == '0 && cand_energy[k*OUT_EW +: OUT_EW] == '0);
      if (k > 0) begin : g_ord
        p_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (out_valid && cand_valid[k]) |-> cand_valid[k-1] &&
            cand_energy[(k-1)*OUT_EW +: OUT_EW] >= cand_energy[k*OUT_EW +: OUT_EW]);
      end
    end
  endgenerate
endmodule

// File: tb/pcs_peak_select_test.sv
`timescale 1ns/1ps
module pcs_peak_select_test;
  localparam int NC = 64;
  localparam int IW = 12;
  localparam int OW = 10;
  localparam int NK = 4;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic in_ready, out_valid;
  logic [NC-1:0]    in_hit = '0;
  logic [NC*IW-1:0] in_energy = '0;
  logic [NK-1:0]    cand_valid;
  logic [NK*AW-1:0] cand_addr;
  logic [NK*OW-1:0] cand_energy;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pcs_peak_select uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hit(in_hit), .in_energy(in_energy), .out_valid(out_valid),
    .out_ready(out_ready), .cand_valid(cand_valid), .cand_addr(cand_addr),
    .cand_energy(cand_energy)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [OW-1:0] sat(input logic [IW-1:0] e);
    return (e > 12'd1023) ? 10'd1023 : e[OW-1:0];
  endfunction

  logic [NK-1:0]    ev;
  logic [NK*AW-1:0] ea;
  logic [NK*OW-1:0] ee;

  task automatic model();
    logic [NC-1:0] taken;
    taken = '0; ev = '0; ea = '0; ee = '0;
    for (int s = 0; s < NK; s++) begin
      int best;
      logic [OW-1:0] be;
      best = -1; be = '0;
      for (int i = 0; i < NC; i++) begin
        if (in_hit[i] && !taken[i] && (best < 0 || sat(in_energy[i*IW +: IW]) > be)) begin
          best = i; be = sat(in_energy[i*IW +: IW]);
        end
      end
      if (best >= 0) begin
        taken[best] = 1'b1;
        ev[s] = 1'b1;
        ea[s*AW +: AW] = AW'(best);
        ee[s*OW +: OW] = be;
      end
    end
  endtask

  task automatic run_event(input int hold, input string tag);
    logic [NK-1:0] sv; logic [NK*AW-1:0] sa; logic [NK*OW-1:0] se;
    model();
    @(negedge clk);
    check(in_ready === 1'b1, {"R1 ready idle ", tag}, in_ready, 1);
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check(in_ready === 1'b0, {"R1 busy not ready ", tag}, in_ready, 0);
    repeat (NC - 1) @(negedge clk);
    check(out_valid === 1'b0, {"R2 not early ", tag}, out_valid, 0);
    @(negedge clk);
    check(out_valid === 1'b1, {"R2 on time ", tag}, out_valid, 1);
    for (int k = 0; k < NK; k++) begin
      check(cand_valid[k] === ev[k] && cand_addr[k*AW +: AW] === ea[k*AW +: AW]
            && cand_energy[k*OW +: OW] === ee[k*OW +: OW],
            {"R4 R5 R6 R7 R8 R9 slot ", tag},
            {cand_valid[k], cand_addr[k*AW +: AW], cand_energy[k*OW +: OW]},
            {ev[k], ea[k*AW +: AW], ee[k*OW +: OW]});
    end
    sv = cand_valid; sa = cand_addr; se = cand_energy;
    repeat (hold) @(negedge clk);
    check(out_valid === 1'b1 && in_ready === 1'b0 && cand_valid === sv
          && cand_addr === sa && cand_energy === se,
          {"R3 hold ", tag}, {out_valid, cand_energy}, {1'b1, se});
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    check(out_valid === 1'b0 && in_ready === 1'b1, {"R3 release ", tag},
          {out_valid, in_ready}, 2'b01);
  endtask

  task automatic fill(input int density, input int emax);
    for (int i = 0; i < NC; i++) begin
      case (density)
        0: in_hit[i] = 1'b0;
        1: in_hit[i] = ($urandom % 16) == 0;
        2: in_hit[i] = $urandom % 2;
        default: in_hit[i] = 1'b1;
      endcase
      in_energy[i*IW +: IW] = IW'($urandom % (emax + 1));
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0 && cand_valid === '0
          && cand_addr === '0 && cand_energy === '0, "R10 reset",
          {in_ready, out_valid, cand_valid}, 6'b100000);
    rst_n = 1;
    @(negedge clk);
    check(in_ready === 1'b1 && out_valid === 1'b0, "R10 after release", {in_ready, out_valid}, 2'b10);

    // R9: nothing flagged, large energies everywhere
    fill(0, 4095); run_event(0, "empty");
    // R7 R8: single cell at the last address, saturating energy
    in_hit = '0; in_hit[63] = 1'b1; in_energy[63*IW +: IW] = 12'hFFF;
    run_event(2, "single sat");
    // R6: all flagged, equal energy -> addresses 0..3
    in_hit = '1;
    for (int i = 0; i < NC; i++) in_energy[i*IW +: IW] = 12'd77;
    run_event(1, "all tie");
    // R4: huge unflagged energies, small flagged ones
    for (int i = 0; i < NC; i++) begin
      in_hit[i] = (i % 9 == 4);
      in_energy[i*IW +: IW] = in_hit[i] ? IW'(i) : 12'hFFE;
    end
    run_event(0, "unflagged");
    // R8: values straddling the clip point, raw order differs from reported
    in_hit = '0;
    in_hit[5] = 1; in_energy[5*IW +: IW] = 12'd4000;
    in_hit[9] = 1; in_energy[9*IW +: IW] = 12'd1024;
    in_hit[20] = 1; in_energy[20*IW +: IW] = 12'd1023;
    in_hit[30] = 1; in_energy[30*IW +: IW] = 12'd1022;
    in_hit[2] = 1; in_energy[2*IW +: IW] = 12'd3000;
    run_event(3, "clip edge");

    for (int n = 0; n < 40; n++) begin
      int d, em;
      d = n % 4;
      em = (n % 3 == 0) ? 7 : ((n % 3 == 1) ? 1023 : 4095);
      fill(d, em);
      run_event($urandom % 5, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule